// File: doc/BRIEF.md
# Memory Access Fault Classifier

This unit runs beside a two-level translation table walker and decides whether a memory access must abort. For every qualified access it looks at the access address, size and kind (instruction fetch or data), the alignment-check enable, the first-level and optional second-level descriptors returned by the walker, and the 32-bit domain access register. It then reports the single highest-priority reason to abort.

The priority is fixed. An alignment problem wins over everything. A missing first-level entry comes next, then a missing second-level entry for page mappings, and last a domain that forbids the access. When the selected domain is a client domain and nothing else faults, the unit raises a one-cycle request so that a separate permission stage checks the access-permission bits. Manager domains pass with no such request. All results are registered and appear one clock after the access is presented.

Top module: `mmu_access_fault_chk`

## Requirements
- R1: A synchronous active-high reset clears the fault strobe, the fault code (0), the faulting domain (0) and the permission request on the next clock edge.
- R2: With alignment checking enabled, a data access of size word (size code 10, and 11 treated the same) whose address bits [1:0] are not 00 reports fault code 1 (alignment).
- R3: With alignment checking enabled, a data halfword access (size code 01) reports fault code 1 when address bit 0 is 1, and no alignment fault when bit 0 is 0 (even if bit 1 is 1).
- R4: Byte accesses (size code 00), instruction fetches, and any access while alignment checking is disabled never report an alignment fault.
- R5: An alignment fault takes priority over every other check: the code is 1, the reported domain is 0 and no permission request is raised, whatever the descriptors and domain register hold.
- R6: A first-level descriptor with bits [1:0] = 00 reports fault code 2 (section translation) with domain 0, even when a second-level descriptor is supplied.
- R7: For a page mapping (first-level bits [1:0] = 01 or 11) with a second-level descriptor present, second-level bits [1:0] = 00 report fault code 3 (page translation) with the first-level domain; when no second-level descriptor is present it is not checked. This check ranks above the domain check.
- R8: First-level bits [8:5] select domain d, whose access value is domain-register bits [2d+1:2d]. A value of 00 or 10 reports fault code 4 for a section mapping (first-level bits [1:0] = 10) or code 5 for a page mapping, with domain number d.
- R9: A domain value of 11 lets the access pass with code 0, no strobe and no request; a value of 01 with no other fault raises the permission request for one cycle with code 0 and no strobe.
- R10: Results are registered: they appear in the cycle after the access is sampled, last one cycle, and a cycle with access-valid low produces no strobe, code 0, domain 0 and no request whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Qualifies the access inputs this cycle |
| acc_addr | input | 32 | Access virtual address |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_is_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| align_chk_en | input | 1 | Alignment checking enable |
| l1_desc | input | 32 | First-level descriptor from the walker |
| l2_present | input | 1 | Second-level descriptor supplied this cycle |
| l2_desc | input | 32 | Second-level descriptor from the walker |
| dacr | input | 32 | Domain access register, 16 two-bit fields |
| flt_valid | output | 1 | One-cycle abort strobe |
| flt_code | output | 3 | 0 none, 1 alignment, 2 section translation, 3 page translation, 4 section domain, 5 page domain |
| flt_domain | output | 4 | Domain number of a page translation or domain fault, else 0 |
| perm_req | output | 1 | One-cycle request for an access-permission check |

## Verification
The unit holds no state across accesses beyond its output register, so a wrong decision shows at the ports exactly one cycle after the offending access, as a wrong code, a wrong domain number, or a strobe and a request raised together. Priority errors only appear when two fault causes coincide, so the stimulus deliberately stacks them: a misaligned access with an invalid first-level entry, an invalid second-level entry under a client domain, and an invalid first-level entry beside a supplied second-level one. A stale output register would show as a strobe or request persisting into an idle cycle.

// File: rtl/mmu_fault_pkg.sv
package mmu_fault_pkg;

    // Geometry shared by the unit and its checker
    localparam int NUM_DOMAINS = 16;
    localparam int DOM_IDX_W   = $clog2(NUM_DOMAINS);
    localparam int DOM_FIELD_W = 2;
    localparam int DESC_DOM_LSB = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    typedef enum logic [2:0] {
        FT_NONE      = 3'd0,
        FT_ALIGN     = 3'd1,
        FT_SECT_XLAT = 3'd2,
        FT_PAGE_XLAT = 3'd3,
        FT_SECT_DOM  = 3'd4,
        FT_PAGE_DOM  = 3'd5
    } fault_code_e;

    typedef enum logic [1:0] {
        DA_NONE    = 2'b00,
        DA_CLIENT  = 2'b01,
        DA_RSVD    = 2'b10,
        DA_MANAGER = 2'b11
    } dom_access_e;

    typedef enum logic [1:0] {
        L1_INVALID = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef struct packed {
        logic                  valid;
        fault_code_e           code;
        logic [DOM_IDX_W-1:0]  dom;
        logic                  perm;
    } fault_rpt_t;

    // Domain values that forbid any access
    function automatic logic dom_denies(input logic [DOM_FIELD_W-1:0] v);
        return (v == DA_NONE) || (v == DA_RSVD);
    endfunction

    // Page mappings go through a second-level table
    function automatic logic kind_is_page(input logic [1:0] k);
        return (k == L1_COARSE) || (k == L1_FINE);
    endfunction

endpackage

// File: rtl/mmu_align_chk.sv
module mmu_align_chk
    import mmu_fault_pkg::*;
#(
    parameter int LOW_BITS = 2
) (
    input  logic                chk_en,
    input  logic                is_fetch,
    input  logic [1:0]          size,
    input  logic [LOW_BITS-1:0] addr_lo,
    output logic                misaligned
);
    logic half_bad;
    logic word_bad;
    acc_size_e sz;

    assign sz       = acc_size_e'(size);
    assign half_bad = addr_lo[0];
    assign word_bad = |addr_lo;

    always_comb begin
        misaligned = 1'b0;
        if (chk_en && !is_fetch) begin
            unique case (sz)
                SZ_BYTE:              misaligned = 1'b0;
                SZ_HALF:              misaligned = half_bad;
                SZ_WORD, SZ_WORD_ALT: misaligned = word_bad;
            endcase
        end
    end
endmodule

// File: rtl/mmu_domain_sel.sv
module mmu_domain_sel
    import mmu_fault_pkg::*;
#(
    parameter int N_DOM   = NUM_DOMAINS,
    parameter int FIELD_W = DOM_FIELD_W,
    localparam int IDX_W  = $clog2(N_DOM)
) (
    input  logic [N_DOM*FIELD_W-1:0] dacr,
    input  logic [IDX_W-1:0]         idx,
    output logic [FIELD_W-1:0]       access
);
    logic [FIELD_W-1:0] fields [N_DOM];

    for (genvar d = 0; d < N_DOM; d++) begin : g_field
        assign fields[d] = dacr[d*FIELD_W +: FIELD_W];
    end

    assign access = fields[idx];
endmodule

// File: rtl/mmu_desc_chk.sv
module mmu_desc_chk
    import mmu_fault_pkg::*;
#(
    parameter int DESC_W  = 32,
    parameter int DOM_LSB = DESC_DOM_LSB,
    parameter int IDX_W   = DOM_IDX_W
) (
    input  logic [DESC_W-1:0] l1_desc,
    input  logic              l2_present,
    input  logic [DESC_W-1:0] l2_desc,
    output logic              l1_invalid,
    output logic              is_page,
    output logic              l2_invalid,
    output logic [IDX_W-1:0]  dom_idx
);
    l1_kind_e kind;

    assign kind       = l1_kind_e'(l1_desc[1:0]);
    assign l1_invalid = (kind == L1_INVALID);
    assign is_page    = kind_is_page(kind);
    assign l2_invalid = is_page && l2_present && (l2_desc[1:0] == 2'b00);
    assign dom_idx    = l1_desc[DOM_LSB +: IDX_W];
endmodule

// File: rtl/mmu_access_fault_chk.sv
module mmu_access_fault_chk
    import mmu_fault_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DESC_W  = 32,
    parameter int N_DOM   = NUM_DOMAINS,
    parameter int DOM_LSB = DESC_DOM_LSB,
    localparam int IDX_W  = $clog2(N_DOM),
    localparam int DACR_W = N_DOM * DOM_FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_is_fetch,
    input  logic              align_chk_en,
    input  logic [DESC_W-1:0] l1_desc,
    input  logic              l2_present,
    input  logic [DESC_W-1:0] l2_desc,
    input  logic [DACR_W-1:0] dacr,
    output logic              flt_valid,
    output logic [2:0]        flt_code,
    output logic [IDX_W-1:0]  flt_domain,
    output logic              perm_req
);
    logic                   misaligned;
    logic                   l1_invalid;
    logic                   is_page;
    logic                   l2_invalid;
    logic [IDX_W-1:0]       dom_idx;
    logic [DOM_FIELD_W-1:0] dom_acc;

    typedef struct packed {
        logic                 valid;
        fault_code_e          code;
        logic [IDX_W-1:0]     dom;
        logic                 perm;
    } rpt_t;

    rpt_t nxt_rpt;
    rpt_t rpt_q;

    mmu_align_chk #(.LOW_BITS(2)) u_align (
        .chk_en     (align_chk_en),
        .is_fetch   (acc_is_fetch),
        .size       (acc_size),
        .addr_lo    (acc_addr[1:0]),
        .misaligned (misaligned)
    );

    mmu_desc_chk #(
        .DESC_W  (DESC_W),
        .DOM_LSB (DOM_LSB),
        .IDX_W   (IDX_W)
    ) u_desc (
        .l1_desc    (l1_desc),
        .l2_present (l2_present),
        .l2_desc    (l2_desc),
        .l1_invalid (l1_invalid),
        .is_page    (is_page),
        .l2_invalid (l2_invalid),
        .dom_idx    (dom_idx)
    );

    mmu_domain_sel #(
        .N_DOM   (N_DOM),
        .FIELD_W (DOM_FIELD_W)
    ) u_dsel (
        .dacr   (dacr),
        .idx    (dom_idx),
        .access (dom_acc)
    );

    // Fixed priority: alignment, first-level, second-level, domain
    always_comb begin
        nxt_rpt       = '0;
        nxt_rpt.code  = FT_NONE;
        if (acc_valid) begin
            if (misaligned) begin
                nxt_rpt.valid = 1'b1;
                nxt_rpt.code  = FT_ALIGN;
            end else if (l1_invalid) begin
                nxt_rpt.valid = 1'b1;
                nxt_rpt.code  = FT_SECT_XLAT;
            end else if (l2_invalid) begin
                nxt_rpt.valid = 1'b1;
                nxt_rpt.code  = FT_PAGE_XLAT;
                nxt_rpt.dom   = dom_idx;
            end else if (dom_denies(dom_acc)) begin
                nxt_rpt.valid = 1'b1;
                nxt_rpt.code  = is_page ? FT_PAGE_DOM : FT_SECT_DOM;
                nxt_rpt.dom   = dom_idx;
            end else if (dom_acc == DA_CLIENT) begin
                nxt_rpt.perm  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_q      <= '0;
            rpt_q.code <= FT_NONE;
        end else begin
            rpt_q <= nxt_rpt;
        end
    end

    assign flt_valid  = rpt_q.valid;
    assign flt_code   = rpt_q.code;
    assign flt_domain = rpt_q.dom;
    assign perm_req   = rpt_q.perm;
endmodule

// File: rtl/mmu_access_fault_chk_sva.sv
module mmu_access_fault_chk_sva
    import mmu_fault_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DESC_W  = 32,
    parameter int N_DOM   = NUM_DOMAINS,
    parameter int DOM_LSB = DESC_DOM_LSB,
    localparam int IDX_W  = $clog2(N_DOM),
    localparam int DACR_W = N_DOM * DOM_FIELD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_is_fetch,
    input logic              align_chk_en,
    input logic [DESC_W-1:0] l1_desc,
    input logic              l2_present,
    input logic [DESC_W-1:0] l2_desc,
    input logic [DACR_W-1:0] dacr,
    input logic              flt_valid,
    input logic [2:0]        flt_code,
    input logic [IDX_W-1:0]  flt_domain,
    input logic              perm_req
);
    logic [DACR_W-1:0] dacr_sh;
    assign dacr_sh = dacr >> (DOM_FIELD_W * int'(l1_desc[DOM_LSB +: IDX_W]));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!flt_valid && flt_code == 3'd0 && !perm_req && flt_domain == '0));

    assert_word_align_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && align_chk_en && !acc_is_fetch && acc_size[1] && acc_addr[1:0] != 2'b00)
        |=> (flt_valid && flt_code == 3'd1));

    assert_fetch_no_align_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_is_fetch || !align_chk_en || acc_size == 2'b00))
        |=> (flt_code != 3'd1));

    assert_align_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (flt_code == 3'd1) |-> (flt_domain == '0 && !perm_req));

    assert_l1_invalid_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !align_chk_en && l1_desc[1:0] == 2'b00)
        |=> (flt_valid && flt_code == 3'd2));

    assert_sect_domain_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !align_chk_en && l1_desc[1:0] == 2'b10 && dacr_sh[0] == 1'b0)
        |=> (flt_valid && flt_code == 3'd4));

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(flt_valid && perm_req));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!flt_valid && !perm_req && flt_code == 3'd0));
endmodule

bind mmu_access_fault_chk mmu_access_fault_chk_sva #(
    .ADDR_W  (ADDR_W),
    .DESC_W  (DESC_W),
    .N_DOM   (N_DOM),
    .DOM_LSB (DOM_LSB)
) u_sva (.*);

// File: tb/test_mmu_access_fault_chk.sv
module test_mmu_access_fault_chk;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DACR_V = 32'h4000_00E4; // d0=00 d1=01 d2=10 d3=11 d15=01

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        fetch;
        logic        aen;
        logic [31:0] l1;
        logic        l2p;
        logic [31:0] l2;
        logic [2:0]  ecode;
        logic [3:0]  edom;
        logic        eperm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h1001, 2'b10, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd1, 4'd0,  1'b0, 4'd2},  // R2
        '{32'h1002, 2'b11, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd1, 4'd0,  1'b0, 4'd2},  // R2
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd0, 4'd0,  1'b0, 4'd9},  // R9 manager
        '{32'h1001, 2'b01, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd1, 4'd0,  1'b0, 4'd3},  // R3
        '{32'h1002, 2'b01, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd0, 4'd0,  1'b0, 4'd3},  // R3
        '{32'h1003, 2'b00, 1'b0, 1'b1, 32'h62,  1'b0, 32'h0, 3'd0, 4'd0,  1'b0, 4'd4},  // R4 byte
        '{32'h1003, 2'b10, 1'b1, 1'b1, 32'h62,  1'b0, 32'h0, 3'd0, 4'd0,  1'b0, 4'd4},  // R4 fetch
        '{32'h1003, 2'b10, 1'b0, 1'b0, 32'h62,  1'b0, 32'h0, 3'd0, 4'd0,  1'b0, 4'd4},  // R4 disabled
        '{32'h1001, 2'b10, 1'b0, 1'b1, 32'h0,   1'b1, 32'h0, 3'd1, 4'd0,  1'b0, 4'd5},  // R5
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h20,  1'b0, 32'h0, 3'd2, 4'd0,  1'b0, 4'd6},  // R6
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h21,  1'b1, 32'h0, 3'd3, 4'd1,  1'b0, 4'd7},  // R7 client
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h41,  1'b1, 32'h2, 3'd5, 4'd2,  1'b0, 4'd8},  // R8 page rsvd
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h02,  1'b0, 32'h0, 3'd4, 4'd0,  1'b0, 4'd8},  // R8 no access
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h42,  1'b0, 32'h0, 3'd4, 4'd2,  1'b0, 4'd8},  // R8 reserved
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h22,  1'b0, 32'h0, 3'd0, 4'd0,  1'b1, 4'd9},  // R9 client
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h1E2, 1'b0, 32'h0, 3'd0, 4'd0,  1'b1, 4'd8},  // R8 domain 15
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h63,  1'b1, 32'h1, 3'd0, 4'd0,  1'b0, 4'd9},  // R9 fine page
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h21,  1'b0, 32'h0, 3'd0, 4'd0,  1'b1, 4'd7},  // R7 no L2
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h01,  1'b1, 32'h2, 3'd5, 4'd0,  1'b0, 4'd8},  // R8 page none
        '{32'h1000, 2'b10, 1'b0, 1'b1, 32'h20,  1'b1, 32'h0, 3'd2, 4'd0,  1'b0, 4'd6}   // R6 over L2
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic        acc_is_fetch;
    logic        align_chk_en;
    logic [31:0] l1_desc;
    logic        l2_present;
    logic [31:0] l2_desc;
    logic [31:0] dacr;
    logic        flt_valid;
    logic [2:0]  flt_code;
    logic [3:0]  flt_domain;
    logic        perm_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_access_fault_chk i_mmu_access_fault_chk (
        .clk, .rst, .acc_valid, .acc_addr, .acc_size, .acc_is_fetch,
        .align_chk_en, .l1_desc, .l2_present, .l2_desc, .dacr,
        .flt_valid, .flt_code, .flt_domain, .perm_req
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic v, input logic [2:0] c,
                             input logic [3:0] d, input logic p);
        check(req, "flt_valid",  32'(flt_valid),  32'(v));
        check(req, "flt_code",   32'(flt_code),   32'(c));
        check(req, "flt_domain", 32'(flt_domain), 32'(d));
        check(req, "perm_req",   32'(perm_req),   32'(p));
    endtask

    task automatic drive(input vec_t v);
        acc_valid    = 1'b1;
        acc_addr     = v.addr;
        acc_size     = v.size;
        acc_is_fetch = v.fetch;
        align_chk_en = v.aen;
        l1_desc      = v.l1;
        l2_present   = v.l2p;
        l2_desc      = v.l2;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        acc_valid = 1'b0; acc_addr = '0; acc_size = '0; acc_is_fetch = 1'b0;
        align_chk_en = 1'b0; l1_desc = '0; l2_present = 1'b0; l2_desc = '0;
        dacr = DACR_V;
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0, 3'd0, 4'd0, 1'b0); // reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            acc_valid = 1'b0;
            check_out($sformatf("R%0d", VECS[i].req), VECS[i].ecode != 3'd0,
                      VECS[i].ecode, VECS[i].edom, VECS[i].eperm);
        end

        // R10: result lasts one cycle only
        @(negedge clk);
        drive(VECS[13]);
        @(negedge clk);
        acc_valid = 1'b0;
        check_out("R10", 1'b1, 3'd4, 4'd2, 1'b0);
        @(negedge clk);
        check_out("R10", 1'b0, 3'd0, 4'd0, 1'b0);

        // R10: faulting inputs with access-valid low produce nothing
        drive(VECS[0]);
        acc_valid = 1'b0;
        @(negedge clk);
        check_out("R10", 1'b0, 3'd0, 4'd0, 1'b0);

        // R10: back-to-back accesses each reported in the following cycle
        drive(VECS[14]);
        @(negedge clk);
        check_out("R10", 1'b0, 3'd0, 4'd0, 1'b1);
        drive(VECS[10]);
        @(negedge clk);
        acc_valid = 1'b0;
        check_out("R10", 1'b1, 3'd3, 4'd1, 1'b0);

        // R1: reset wins over a faulting access
        @(negedge clk);
        drive(VECS[11]);
        rst = 1'b1;
        @(negedge clk);
        check_out("R1", 1'b0, 3'd0, 4'd0, 1'b0);
        rst = 1'b0;
        acc_valid = 1'b0;
        @(negedge clk);

        // R8: remap domain 3 to reserved and re-run a section access
        dacr = DACR_V & ~32'h0000_0040;
        drive(VECS[2]);
        @(negedge clk);
        acc_valid = 1'b0;
        check_out("R8", 1'b1, 3'd4, 4'd3, 1'b0);
        dacr = DACR_V;
        @(negedge clk);

        finish_run();
    end
endmodule